// File: doc/BRIEF.md
# Connection Block Power-Mode Controller

This block holds the configuration of one multiplexer-style input connection block in a programmable-logic fabric and turns it into per-switch control lines. Each of the `NUM_SW` connection switches receives a pass enable and two active-low supply enables, one for the high rail and one for the low rail. Exactly one switch is chosen to carry a routing track into the logic block. The other switches are power-gated, with both of their rails cut off. A single gate-all bit shuts down the whole connection block when it is unused.

The configuration word is compact: a binary switch index, one gate-all bit, and, in the full mode, one level bit that picks the rail for the chosen switch. That makes log2(N)+2 bits, or log2(N)+1 bits in the two-state mode. In the two-state mode the chosen switch always runs on the high rail. The word enters through a serial chain clocked by `cfg_clk` and becomes active only on a load edge. The outputs are decoded from the active word, so they stay static between loads.

The reset input is asserted asynchronously and released synchronously inside the block. Reset leaves every switch power-gated.

Top module: `cb_power_ctrl`

## Requirements
- R1: While reset is applied, and after reset until the first load, every `pass_en` bit is 0 and every `vddh_en_n` and `vddl_en_n` bit is 1.
- R2: On a rising `cfg_clk` edge with `cfg_load` low, `cfg_din` is shifted into the chain. On a rising edge with `cfg_load` high, the last CW bits shifted in become the active word, with the first-shifted bit as the MSB. Outputs change only after such a load edge. The word layout is: index in bits [SELW-1:0], level bit at bit SELW (full mode only), gate-all in bit CW-1.
- R3: With gate-all 0, `pass_en[index]` is 1 and every other `pass_en` bit is 0.
- R4: With gate-all 1, every `pass_en` bit is 0 and every rail enable is 1, whatever the other bits hold.
- R5: In the full mode, the chosen switch gets `vddh_en_n`=0 and `vddl_en_n`=1 when the level bit is 1, and `vddh_en_n`=1 and `vddl_en_n`=0 when the level bit is 0.
- R6: Any switch whose `pass_en` is 0 has both `vddh_en_n` and `vddl_en_n` at 1.
- R7: In the two-state mode (CW = SELW+1, no level bit), the chosen switch gets `vddh_en_n`=0 and `vddl_en_n`=1.
- R8: At no time is more than one `pass_en` bit high. No switch ever has `pass_en`=1 with both rail enables at 0.
- R9: While `cfg_load` stays high across several edges, `cfg_din` is ignored, the chain does not move, and the active word keeps its value.
- R10: Asserting `rst_n` clears the outputs to the R1 state at once, even when a load is presented in the same cycle. Release takes effect on the second `cfg_clk` rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_din | input | 1 | Serial configuration bit, MSB first |
| cfg_load | input | 1 | Transfer the chain into the active word |
| pass_en | output | NUM_SW | Per-switch pass enable, active high |
| vddh_en_n | output | NUM_SW | Per-switch high-rail enable, active low |
| vddl_en_n | output | NUM_SW | Per-switch low-rail enable, active low |

## Verification
Two functions can fall in the same `cfg_clk` cycle: shifting and loading, and loading and reset. For the first, the bench holds `cfg_load` high for several edges while `cfg_din` toggles. A chain that moved under load would change the recaptured word, and the outputs would show it. For the second, the bench presents a load with a freshly shifted word in the same cycle as reset is asserted, and expects the all-gated state instead of the new word. A behavioural model built on a bit queue predicts all outputs of four instances (8 and 32 switches, in both modes). It covers every possible configuration word, and the outputs are compared with it on every clock.

// File: rtl/cbpc_pkg.sv
package cbpc_pkg;

  // Width of the binary switch index for a connection block of n switches.
  function automatic int sel_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Configuration word width: index, gate-all, plus a level bit in full mode.
  function automatic int cfg_bits(input int n, input bit two_state);
    return sel_bits(n) + (two_state ? 1 : 2);
  endfunction

endpackage

// File: rtl/cbpc_rst_sync.sv
module cbpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cbpc_cfg_chain.sv
module cbpc_cfg_chain #(
  parameter int              CW       = 7,
  parameter logic [CW-1:0]   RST_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          load,
  output logic [CW-1:0] word
);

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] shadow_d;
  logic          chain_en;
  logic          shadow_en;

  // Shift only while no load is requested; capture only on load.
  always_comb begin
    chain_en  = !load;
    shadow_en = load;
    chain_d   = {chain_q[CW-2:0], din};
    shadow_d  = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (chain_en) begin
      chain_q <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_WORD;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  assign word = shadow_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow_q)); // R2

  AST_CHAIN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(chain_q)); // R9

endmodule

// File: rtl/cbpc_onehot_dec.sv
module cbpc_onehot_dec #(
  parameter int NUM_SW = 32,
  parameter int SELW   = 5
) (
  input  logic [SELW-1:0]   sel,
  input  logic              gate_all,
  output logic [NUM_SW-1:0] hot
);

  // One output per switch; gate_all forces every output low.
  for (genvar i = 0; i < NUM_SW; i++) begin : g_out
    assign hot[i] = !gate_all && (sel == SELW'(i));
  end

endmodule

// File: rtl/cbpc_rail_gen.sv
module cbpc_rail_gen #(
  parameter int NUM_SW = 32
) (
  input  logic [NUM_SW-1:0] hot,
  input  logic              vdd_sel,
  output logic [NUM_SW-1:0] pass_en,
  output logic [NUM_SW-1:0] vddh_en_n,
  output logic [NUM_SW-1:0] vddl_en_n
);

  // Two NAND2 per switch: a deselected switch always drives both rails off.
  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign pass_en[i]   = hot[i];
    assign vddh_en_n[i] = ~(hot[i] & vdd_sel);
    assign vddl_en_n[i] = ~(hot[i] & ~vdd_sel);
  end

endmodule

// File: rtl/cb_power_ctrl.sv
module cb_power_ctrl #(
  parameter int NUM_SW    = 32,
  parameter bit TWO_STATE = 1'b0
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              cfg_din,
  input  logic              cfg_load,
  output logic [NUM_SW-1:0] pass_en,
  output logic [NUM_SW-1:0] vddh_en_n,
  output logic [NUM_SW-1:0] vddl_en_n
);
  import cbpc_pkg::*;

  localparam int            SELW     = sel_bits(NUM_SW);
  localparam int            CW       = cfg_bits(NUM_SW, TWO_STATE);
  localparam logic [CW-1:0] RST_WORD = {1'b1, {(CW-1){1'b0}}};

  logic              rst_sync_n;
  logic [CW-1:0]     word;
  logic [SELW-1:0]   sel_idx;
  logic              gate_all;
  logic              vdd_sel;
  logic [NUM_SW-1:0] hot;

  cbpc_rst_sync i_rst_sync (
    .clk        (cfg_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbpc_cfg_chain #(
    .CW       (CW),
    .RST_WORD (RST_WORD)
  ) i_chain (
    .clk   (cfg_clk),
    .rst_n (rst_sync_n),
    .din   (cfg_din),
    .load  (cfg_load),
    .word  (word)
  );

  assign sel_idx  = word[SELW-1:0];
  assign gate_all = word[CW-1];

  // Two-state variant has no level bit: the chosen switch is tied to the high rail.
  if (TWO_STATE) begin : g_fixed_rail
    assign vdd_sel = 1'b1;
  end else begin : g_prog_rail
    assign vdd_sel = word[SELW];
  end

  cbpc_onehot_dec #(
    .NUM_SW (NUM_SW),
    .SELW   (SELW)
  ) i_dec (
    .sel      (sel_idx),
    .gate_all (gate_all),
    .hot      (hot)
  );

  cbpc_rail_gen #(
    .NUM_SW (NUM_SW)
  ) i_rails (
    .hot       (hot),
    .vdd_sel   (vdd_sel),
    .pass_en   (pass_en),
    .vddh_en_n (vddh_en_n),
    .vddl_en_n (vddl_en_n)
  );

  AST_SINGLE_PASS: assert property (@(posedge cfg_clk) disable iff (!rst_sync_n)
    $onehot0(pass_en)); // R8

  AST_NO_DUAL_RAIL: assert property (@(posedge cfg_clk) disable iff (!rst_sync_n)
    (pass_en & ~vddh_en_n & ~vddl_en_n) == '0); // R8

  AST_IDLE_GATED: assert property (@(posedge cfg_clk) disable iff (!rst_sync_n)
    (~pass_en & ~(vddh_en_n & vddl_en_n)) == '0); // R6

  AST_RAIL_PER_PASS: assert property (@(posedge cfg_clk) disable iff (!rst_sync_n)
    ($countones(~vddh_en_n) + $countones(~vddl_en_n)) == $countones(pass_en)); // R5

  AST_GATE_ALL_OFF: assert property (@(posedge cfg_clk) disable iff (!rst_sync_n)
    gate_all |-> (pass_en == '0)); // R4

endmodule

// File: tb/test_cb_power_ctrl.sv
module test_cb_power_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_load = 1'b0;

  logic [31:0] p32f, h32f, l32f, p32g, h32g, l32g;
  logic [7:0]  p8f, h8f, l8f, p8g, h8g, l8g;

  int  checks = 0;
  int  errors = 0;
  bit  cmp_on = 1'b0;
  bit  finished = 1'b0;

  // Reference model state
  bit       q[$];
  logic [6:0] m_word = '0;
  bit       m_rst = 1'b1;

  always #2.5 clk = ~clk;

  cb_power_ctrl #(.NUM_SW(32), .TWO_STATE(1'b0)) i_cb_power_ctrl (
    .cfg_clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .cfg_load(cfg_load),
    .pass_en(p32f), .vddh_en_n(h32f), .vddl_en_n(l32f));

  cb_power_ctrl #(.NUM_SW(8), .TWO_STATE(1'b0)) i_cb_power_ctrl_8f (
    .cfg_clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .cfg_load(cfg_load),
    .pass_en(p8f), .vddh_en_n(h8f), .vddl_en_n(l8f));

  cb_power_ctrl #(.NUM_SW(32), .TWO_STATE(1'b1)) i_cb_power_ctrl_32g (
    .cfg_clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .cfg_load(cfg_load),
    .pass_en(p32g), .vddh_en_n(h32g), .vddl_en_n(l32g));

  cb_power_ctrl #(.NUM_SW(8), .TWO_STATE(1'b1)) i_cb_power_ctrl_8g (
    .cfg_clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .cfg_load(cfg_load),
    .pass_en(p8g), .vddh_en_n(h8g), .vddl_en_n(l8g));

  function automatic logic [6:0] last7();
    logic [6:0] r = '0;
    for (int i = 0; i < 7; i++) begin
      if (q.size() > i) r[i] = q[q.size() - 1 - i];
    end
    return r;
  endfunction

  // Behavioural model: serial queue, word taken on load, reset clears.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_rst <= 1'b1;
    end else if (cfg_load) begin
      m_word <= last7();
      m_rst  <= 1'b0;
    end else begin
      q.push_back(cfg_din);
      if (q.size() > 16) void'(q.pop_front());
    end
  end

  function automatic void calc(input int n, input bit gate,
                               output logic [31:0] p, output logic [31:0] h,
                               output logic [31:0] l, output bit dis);
    int selw = $clog2(n);
    int cw   = selw + (gate ? 1 : 2);
    int sel;
    bit vs;
    logic [31:0] mk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    p = '0; h = mk; l = mk;
    dis = m_rst ? 1'b1 : m_word[cw-1];
    sel = int'(m_word) & ((1 << selw) - 1);
    vs  = gate ? 1'b1 : m_word[selw];
    if (!dis) begin
      p[sel] = 1'b1;
      if (vs) h[sel] = 1'b0;
      else    l[sel] = 1'b0;
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp(input int n, input bit gate,
                     input logic [31:0] p, input logic [31:0] h, input logic [31:0] l);
    logic [31:0] ep, eh, el;
    logic [31:0] mk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    bit dis;
    calc(n, gate, ep, eh, el, dis);
    chk(dis ? "R4" : "R3", p & mk, ep);
    chk(dis ? "R4" : (gate ? "R7" : "R5"), h & mk, eh);
    chk(dis ? "R4" : (gate ? "R7" : "R5"), l & mk, el);
    chk("R6", (~p & ~(h & l)) & mk, 32'h0);
    chk("R8", 32'($countones(p & mk) > 1), 32'h0);
    chk("R8", p & ~h & ~l & mk, 32'h0);
  endtask

  // Cycle-by-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      cmp(32, 1'b0, p32f, h32f, l32f);
      cmp(8,  1'b0, 32'(p8f), 32'(h8f), 32'(l8f));
      cmp(32, 1'b1, p32g, h32g, l32g);
      cmp(8,  1'b1, 32'(p8g), 32'(h8g), 32'(l8g));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cfg_din = 1'b0; cfg_load = 1'b0;
    end
  endtask

  task automatic shift_bits(input logic [6:0] w);
    for (int b = 6; b >= 0; b--) begin
      @(negedge clk); #1;
      cfg_din = w[b]; cfg_load = 1'b0;
    end
  endtask

  task automatic load_once();
    @(negedge clk); #1;
    cfg_load = 1'b1; cfg_din = 1'b0;
    @(negedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [31:0] hold_p, hold_h, hold_l;
    @(negedge clk);
    cmp_on = 1'b1;
    idle(3);
    // R1: reset state
    chk("R1", p32f, 32'h0);
    chk("R1", h32f & l32f, 32'hFFFF_FFFF);
    @(negedge clk); #1; rst_n = 1'b1;
    idle(4);
    // R1: still gated after release, before any load
    chk("R1", 32'(p8g), 32'h0);
    chk("R1", 32'(h8f & l8f), 32'h0000_00FF);

    // R3/R5/R7: word 0100101 -> N32 full: sel 5 high rail; N8 full: sel 5 low rail; N8 two-state: sel 5
    shift_bits(7'b0100101);
    load_once();
    chk("R3", p32f, 32'h0000_0020);
    chk("R5", h32f, ~32'h0000_0020);
    chk("R5", l32f, 32'hFFFF_FFFF);
    chk("R5", 32'(l8f), 32'h0000_00DF);
    chk("R7", 32'(h8g), 32'h0000_00DF);
    chk("R7", 32'(l8g), 32'h0000_00FF);

    // R2: shifting without load leaves outputs unchanged
    hold_p = p32f; hold_h = h32f; hold_l = l32f;
    shift_bits(7'b1111111);
    idle(1);
    chk("R2", p32f, hold_p);
    chk("R2", h32f ^ hold_h, 32'h0);
    chk("R2", l32f ^ hold_l, 32'h0);
    // R4: all ones word sets gate-all in every instance
    load_once();
    chk("R4", p32f | p32g, 32'h0);
    chk("R4", h32f & l32f, 32'hFFFF_FFFF);

    // R9: load held high while din toggles; word 0010011 -> sel 19 low rail
    shift_bits(7'b0010011);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      cfg_load = 1'b1; cfg_din = i[0];
    end
    @(negedge clk);
    chk("R9", p32f, 32'h0008_0000);
    chk("R9", l32f, ~32'h0008_0000);
    #1; cfg_load = 1'b0;

    // R10: reset asserted in the same cycle a new word is loaded
    shift_bits(7'b0100000);
    @(negedge clk); #1;
    cfg_load = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    chk("R10", p32f | 32'(p8f), 32'h0);
    chk("R10", h32f & l32f, 32'hFFFF_FFFF);
    #1; cfg_load = 1'b0;
    @(negedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R10", p32f, 32'h0);
    idle(3);

    // Every configuration word, all four instances compared by the model
    for (int w = 0; w < 128; w++) begin
      shift_bits(7'(w));
      load_once();
    end
    idle(2);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule